// File: doc/BRIEF.md
# Fixed-Priority Restart Interrupt Controller

This block collects five interrupt requests for a small 8-bit CPU core and decides, at each instruction boundary that the core announces, which one is serviced. The requests are a non-maskable trap, three maskable restart lines (high, middle and low restart) that each jump to a fixed address, and a general request whose opcode is supplied by an external device. Every request first passes through a two-flop synchronizer.

The trap needs a rising edge and must still be high when it is serviced. The high restart line is captured by a rising-edge latch. The middle and low restart lines and the general request are level sensitive. A three-bit mask register, loaded through a mask-write port, masks the three restart lines one by one. A global enable gates all maskable sources. The core sets and clears the enable, and accepting any maskable source clears it.

When a vectored source wins, the block raises a one-cycle take pulse with a 16-bit restart address. When the general request wins, the block raises a one-cycle acknowledge for the external device.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several sources qualify at the same boundary, the winner follows the fixed order trap, high restart, middle restart, low restart, general request. The restart addresses are 0x0024 for the trap, 0x003C for the high restart, 0x0034 for the middle restart and 0x002C for the low restart.
- R2: A write with `mask_we` loads `mask_wdata[0]` as the low-restart mask, `mask_wdata[1]` as the middle-restart mask and `mask_wdata[2]` as the high-restart mask. A masked restart line is never taken. The masks do not affect the trap or the general request. All masks are clear after reset.
- R3: The restart lines and the general request are taken only while the global enable is 1. `gie_set` sets the enable and `gie_clear` clears it. If both are high, the clear wins.
- R4: The trap is taken whatever the global enable and the masks hold.
- R5: The trap is taken only after a rising edge on the synchronized input, and only if the input is still high at the boundary. It is not taken again until a new rising edge arrives.
- R6: A rising edge on the high restart input is held until that source is taken, or until a mask write with `mask_wdata[3]=1` clears it. The held edge survives a falling input and a set mask bit.
- R7: Accepting any maskable source, including the general request, clears the global enable in the same cycle as the output pulse. Taking the trap leaves the enable unchanged.
- R8: When the general request wins, `ext_ack` is high for exactly one cycle and `irq_take` stays low.
- R9: Arbitration happens only in a cycle with `insn_boundary` high. The outputs pulse on the clock edge that ends that cycle, and `irq_take` and `ext_ack` are low in all other cycles.
- R10: A request raised just before a clock edge can win only at the third edge after that change. At the first two edges it is still inside the synchronizer.
- R11: After reset, `irq_take`, `ext_ack` and `int_enabled` are 0 and `irq_vector` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_in | input | 1 | Non-maskable trap request, asynchronous |
| r75_in | input | 1 | High restart request, captured on its rising edge |
| r65_in | input | 1 | Middle restart request, level sensitive |
| r55_in | input | 1 | Low restart request, level sensitive |
| ext_in | input | 1 | General request, serviced by an external device |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| gie_set | input | 1 | Set the global enable |
| gie_clear | input | 1 | Clear the global enable |
| mask_we | input | 1 | Mask-write strobe |
| mask_wdata | input | 4 | Bits 2..0: restart masks (high, middle, low); bit 3: clear the held high-restart edge |
| irq_take | output | 1 | One-cycle pulse: a restart address is valid |
| irq_vector | output | 16 | Restart address, 0 when no pulse |
| ext_ack | output | 1 | One-cycle acknowledge for the general request |
| int_enabled | output | 1 | Current global enable |

## Verification
A stuck bit in the mask register or the global enable appears at the first boundary after the faulty state forms. The block then takes a source it should skip, or skips one it should take, and the wrong address or the missing pulse shows one clock later. A held edge or trap flag that is not cleared gives a second take at the next boundary with no new edge. A flag that never sets gives no take at all. A synchronizer that is shorter or longer than specified moves the first winning boundary by one edge. A bench that holds the boundary strobe high through the synchronizer delay sees this shift.

// File: rtl/irq_pkg.sv
// Package: shared source encoding and restart addresses of the interrupt controller.
// Assumes a 16-bit address space on the core side.
package irq_pkg;

    localparam int VEC_W = 16;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_R75,
        SRC_R65,
        SRC_R55,
        SRC_EXT
    } irq_src_e;

    // Restart address for a winning source; zero for none or the external request.
    function automatic logic [VEC_W-1:0] vec_of(irq_src_e s);
        case (s)
            SRC_TRAP: vec_of = VEC_TRAP;
            SRC_R75:  vec_of = VEC_R75;
            SRC_R65:  vec_of = VEC_R65;
            SRC_R55:  vec_of = VEC_R55;
            default:  vec_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-bit synchronizer: each bit passes through STAGES flops in series.
// Assumes the inputs are independent single-bit requests, so no bus coherency is needed.
module irq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop captures the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_async;
                end
            end else begin : g_next
                // Later flops resolve metastability one more stage each.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/irq_edge_capture.sv
// Edge capture: holds a trap flag (rising edge, cleared when the input drops)
// and a high-restart edge latch (held until taken or cleared by software).
// Assumes its inputs are already synchronized to clk.
module irq_edge_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic trap_s,
    input  logic r75_s,
    input  logic trap_taken,
    input  logic r75_taken,
    input  logic r75_clr,
    output logic trap_pend,
    output logic r75_pend
);

    logic trap_prev;
    logic r75_prev;

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_prev <= 1'b0;
            r75_prev  <= 1'b0;
        end else begin
            trap_prev <= trap_s;
            r75_prev  <= r75_s;
        end
    end

    // Trap flag: a rising edge arms it; a low input or service disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n)              trap_pend <= 1'b0;
        else if (!trap_s)        trap_pend <= 1'b0;
        else if (trap_taken)     trap_pend <= 1'b0;
        else if (!trap_prev)     trap_pend <= 1'b1;
    end

    // High-restart latch: a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      r75_pend <= 1'b0;
        else if (r75_s && !r75_prev)     r75_pend <= 1'b1;
        else if (r75_taken || r75_clr)   r75_pend <= 1'b0;
    end

endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority arbiter: picks one source from the qualified requests.
// Assumes the trap qualifier already includes its edge and level conditions.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic       trap_ok,
    input  logic       r75_pend,
    input  logic       r65_lvl,
    input  logic       r55_lvl,
    input  logic       ext_lvl,
    input  logic [2:0] mask,
    input  logic       gie,
    output irq_src_e   winner
);

    // Priority chain, trap first and independent of enable and masks.
    always_comb begin
        winner = SRC_NONE;
        if (trap_ok)                          winner = SRC_TRAP;
        else if (gie) begin
            if (r75_pend && !mask[2])         winner = SRC_R75;
            else if (r65_lvl && !mask[1])     winner = SRC_R65;
            else if (r55_lvl && !mask[0])     winner = SRC_R55;
            else if (ext_lvl)                 winner = SRC_EXT;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the interrupt controller: synchronizes requests, keeps masks and the
// global enable, arbitrates at instruction boundaries and pulses the result.
// Assumes the core holds insn_boundary for one cycle per boundary.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_in,
    input  logic             r75_in,
    input  logic             r65_in,
    input  logic             r55_in,
    input  logic             ext_in,
    input  logic             insn_boundary,
    input  logic             gie_set,
    input  logic             gie_clear,
    input  logic             mask_we,
    input  logic [3:0]       mask_wdata,
    output logic             irq_take,
    output logic [VEC_W-1:0] irq_vector,
    output logic             ext_ack,
    output logic             int_enabled
);

    localparam int NREQ = 5;

    logic [NREQ-1:0] req_s;
    logic [2:0]      mask_q;
    logic            trap_pend;
    logic            r75_pend;
    irq_src_e        winner;
    logic            accept;
    logic            maskable_acc;

    irq_sync #(.W(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_in, r55_in, r65_in, r75_in, trap_in}),
        .q_sync  (req_s)
    );

    assign accept       = insn_boundary && (winner != SRC_NONE);
    assign maskable_acc = accept && (winner != SRC_TRAP);

    irq_edge_capture u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_s     (req_s[0]),
        .r75_s      (req_s[1]),
        .trap_taken (accept && (winner == SRC_TRAP)),
        .r75_taken  (accept && (winner == SRC_R75)),
        .r75_clr    (mask_we && mask_wdata[3]),
        .trap_pend  (trap_pend),
        .r75_pend   (r75_pend)
    );

    irq_arbiter u_arb (
        .trap_ok  (trap_pend && req_s[0]),
        .r75_pend (r75_pend),
        .r65_lvl  (req_s[2]),
        .r55_lvl  (req_s[3]),
        .ext_lvl  (req_s[4]),
        .mask     (mask_q),
        .gie      (int_enabled),
        .winner   (winner)
    );

    // Mask register, loaded by the mask-write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata[2:0];
    end

    // Global enable: acceptance clears first, then the clear strobe, then the set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)            int_enabled <= 1'b0;
        else if (maskable_acc) int_enabled <= 1'b0;
        else if (gie_clear)    int_enabled <= 1'b0;
        else if (gie_set)      int_enabled <= 1'b1;
    end

    // Output pulses: a restart address or the external acknowledge, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take   <= 1'b0;
            irq_vector <= '0;
            ext_ack    <= 1'b0;
        end else begin
            irq_take   <= accept && (winner != SRC_EXT);
            irq_vector <= (accept && (winner != SRC_EXT)) ? vec_of(winner) : '0;
            ext_ack    <= accept && (winner == SRC_EXT);
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Checker: port-level properties of the interrupt controller, bound to the top.
// Assumes the default restart addresses of irq_pkg.
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             insn_boundary,
    input logic             irq_take,
    input logic [VEC_W-1:0] irq_vector,
    input logic             ext_ack,
    input logic             int_enabled
);

    AST_TAKE_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_take && ext_ack)); // R8

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |=> !ext_ack); // R8

    AST_PULSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take || ext_ack) |-> $past(insn_boundary)); // R9

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vector == VEC_TRAP || irq_vector == VEC_R75 ||
                      irq_vector == VEC_R65  || irq_vector == VEC_R55)); // R1

    AST_MASKABLE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vector != VEC_TRAP) |-> $past(int_enabled)); // R3

    AST_GIE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ack || (irq_take && irq_vector != VEC_TRAP)) |-> !int_enabled); // R7

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |-> (irq_vector == '0)); // R9

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .irq_take      (irq_take),
    .irq_vector    (irq_vector),
    .ext_ack       (ext_ack),
    .int_enabled   (int_enabled)
);

// File: tb/sim_irq_prio_ctrl.sv
// Bench: a vector table for arbitration, then directed tests for reset,
// edges, the synchronizer latency and enable handling.
module sim_irq_prio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, ext_in = 0;
    logic        insn_boundary = 0, gie_set = 0, gie_clear = 0, mask_we = 0;
    logic [3:0]  mask_wdata = '0;
    logic        irq_take, ext_ack, int_enabled;
    logic [15:0] irq_vector;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .trap_in(trap_in), .r75_in(r75_in), .r65_in(r65_in), .r55_in(r55_in), .ext_in(ext_in),
        .insn_boundary(insn_boundary), .gie_set(gie_set), .gie_clear(gie_clear),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .irq_take(irq_take), .irq_vector(irq_vector), .ext_ack(ext_ack), .int_enabled(int_enabled)
    );

    // Row: trap r75 r65 r55 ext | mask[2:0] | gie | take | vector | ack
    typedef struct packed {
        logic        trap, r75, r65, r55, ext;
        logic [2:0]  mask;
        logic        gie;
        logic        take;
        logic [15:0] vec;
        logic        ack;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t TABLE [NROWS] = '{
        '{1,1,1,1,1, 3'b000, 1, 1, 16'h0024, 0}, // all pending: trap first
        '{0,1,1,1,1, 3'b000, 1, 1, 16'h003C, 0}, // high restart next
        '{0,0,1,1,1, 3'b000, 1, 1, 16'h0034, 0}, // middle restart next
        '{0,0,0,1,1, 3'b000, 1, 1, 16'h002C, 0}, // low restart next
        '{0,0,0,0,1, 3'b000, 1, 0, 16'h0000, 1}, // general request last
        '{0,1,1,0,0, 3'b100, 1, 1, 16'h0034, 0}, // R2 high masked
        '{0,1,1,1,1, 3'b111, 1, 0, 16'h0000, 1}, // R2 masks leave general request
        '{0,1,1,1,1, 3'b000, 0, 0, 16'h0000, 0}, // R3 enable off blocks all maskable
        '{1,0,0,0,0, 3'b000, 0, 1, 16'h0024, 0}, // R4 trap with enable off
        '{1,0,0,0,0, 3'b111, 1, 1, 16'h0024, 0}, // R4 trap with all masks
        '{0,0,0,0,0, 3'b000, 1, 0, 16'h0000, 0}, // nothing pending
        '{0,1,1,1,0, 3'b011, 1, 1, 16'h003C, 0}  // R2 low and middle masked
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {trap_in, r75_in, r65_in, r55_in, ext_in} = '0;
        {insn_boundary, gie_set, gie_clear, mask_we} = '0;
        mask_wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr_mask(input logic [3:0] v);
        mask_we = 1; mask_wdata = v;
        @(negedge clk);
        mask_we = 0; mask_wdata = '0;
    endtask

    task automatic en_on();
        gie_set = 1;
        @(negedge clk);
        gie_set = 0;
    endtask

    // One boundary cycle; outputs are sampled at the following negedge.
    task automatic boundary();
        insn_boundary = 1;
        @(negedge clk);
        insn_boundary = 0;
    endtask

    task automatic pulse_r75();
        r75_in = 1;
        repeat (3) @(negedge clk);
        r75_in = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc > WATCHDOG);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R11 reset state
        do_reset();
        @(negedge clk);
        chk("R11", "take", irq_take, 0);
        chk("R11", "ack", ext_ack, 0);
        chk("R11", "enable", int_enabled, 0);
        chk("R11", "vector", irq_vector, 0);

        // R1 table walk (rows also exercise R2, R3, R4 and R8)
        for (int i = 0; i < NROWS; i++) begin
            do_reset();
            wr_mask({1'b0, TABLE[i].mask});
            if (TABLE[i].gie) en_on();
            {trap_in, r75_in, r65_in, r55_in, ext_in} =
                {TABLE[i].trap, TABLE[i].r75, TABLE[i].r65, TABLE[i].r55, TABLE[i].ext};
            repeat (4) @(negedge clk);
            boundary();
            chk("R1", $sformatf("row %0d take", i), irq_take, TABLE[i].take);
            chk("R1", $sformatf("row %0d vector", i), irq_vector, TABLE[i].vec);
            chk("R8", $sformatf("row %0d ack", i), ext_ack, TABLE[i].ack);
        end

        // R7 maskable accept clears the enable; R3 no retake until re-enabled
        do_reset();
        en_on();
        r65_in = 1;
        repeat (4) @(negedge clk);
        boundary();
        chk("R7", "middle taken", irq_vector, 16'h0034);
        chk("R7", "enable cleared", int_enabled, 0);
        boundary();
        chk("R3", "no take while disabled", irq_take, 0);
        en_on();
        boundary();
        chk("R3", "retake after enable", irq_vector, 16'h0034);
        gie_set = 1; gie_clear = 1;
        @(negedge clk);
        gie_set = 0; gie_clear = 0;
        chk("R3", "clear wins over set", int_enabled, 0);

        // R7 trap leaves enable; R5 held trap not retaken
        do_reset();
        en_on();
        trap_in = 1;
        repeat (4) @(negedge clk);
        boundary();
        chk("R7", "trap vector", irq_vector, 16'h0024);
        chk("R7", "enable kept on trap", int_enabled, 1);
        boundary();
        chk("R5", "held trap not retaken", irq_take, 0);

        // R5 trap dropped before boundary is ignored
        do_reset();
        trap_in = 1;
        repeat (4) @(negedge clk);
        trap_in = 0;
        repeat (4) @(negedge clk);
        boundary();
        chk("R5", "dropped trap ignored", irq_take, 0);

        // R6 edge latch survives input fall, cleared by service
        do_reset();
        en_on();
        pulse_r75();
        boundary();
        chk("R6", "latched edge taken", irq_vector, 16'h003C);
        en_on();
        boundary();
        chk("R6", "latch cleared by service", irq_take, 0);

        // R6 latch cleared by mask write bit 3
        do_reset();
        pulse_r75();
        wr_mask(4'b1000);
        en_on();
        boundary();
        chk("R6", "latch cleared by write", irq_take, 0);

        // R6 latch held while masked
        do_reset();
        wr_mask(4'b0100);
        pulse_r75();
        en_on();
        boundary();
        chk("R2", "masked high not taken", irq_take, 0);
        wr_mask(4'b0000);
        boundary();
        chk("R6", "held edge taken after unmask", irq_vector, 16'h003C);

        // R9 no boundary, no output
        do_reset();
        en_on();
        r65_in = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R9", $sformatf("no boundary cycle %0d", k), irq_take, 0);
        end

        // R10 synchronizer latency: win only at the third edge
        do_reset();
        en_on();
        r55_in = 1;
        insn_boundary = 1;
        @(negedge clk);
        chk("R10", "edge 1", irq_take, 0);
        @(negedge clk);
        chk("R10", "edge 2", irq_take, 0);
        @(negedge clk);
        insn_boundary = 0;
        chk("R10", "edge 3 take", irq_take, 1);
        chk("R10", "edge 3 vector", irq_vector, 16'h002C);

        // R8 acknowledge lasts one cycle with boundary held
        do_reset();
        en_on();
        ext_in = 1;
        repeat (4) @(negedge clk);
        insn_boundary = 1;
        @(negedge clk);
        chk("R8", "ack high", ext_ack, 1);
        chk("R8", "no take with ack", irq_take, 0);
        @(negedge clk);
        insn_boundary = 0;
        chk("R8", "ack drops", ext_ack, 0);
        chk("R7", "enable cleared by ack", int_enabled, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule